// File: doc/BRIEF.md
# Multi-Channel Timer and PWM Bank

This block holds a parameterised number of independent 16-bit up-counting timer channels behind a single word-addressed register port. Each channel has a full-compare value, a half-compare value, a writable counter and a control word. The control word picks which synchronous tick inputs drive the channel and how many of those ticks make one count step. A channel counts from 0 to its full-compare value and then returns to 0, which sets the channel's flag. Its PWM output rises when the count reaches the half-compare value and falls when the count wraps.

Three shared vectors hold one bit per channel: run enables, event flags and interrupt masks. Software never writes these vectors directly. A write that carries ones at a set address turns the matching bits on, and a write that carries ones at a clear address turns them off. Bits written as zero keep their value, so two drivers can manage different channels without a read-modify-write. The single interrupt output is high while any unmasked flag is set.

The clock sources arrive as single-cycle enable pulses in the block's own clock domain: the peripheral tick, the slow 32.768 kHz tick and the external tick.

Top module: `pwm_timer_bank`

## Requirements
- R1: After reset the enable and flag vectors are 0, every mask bit is 1, and each channel's counter, compares, control word and PWM output are 0. The interrupt output is low.
- R2: Address 0x00 returns the enable vector, and a write to it has no effect. A write to 0x04 sets the enable bits where the data is 1. A write to 0x08 clears the enable bits where the data is 1. Data bits that are 0 leave their enable bit unchanged.
- R3: Flag bit n belongs to channel n. The flag vector reads at 0x10, its set alias is 0x14 and its clear alias is 0x18. The mask vector reads at 0x20, its set alias is 0x24 and its clear alias is 0x28. Data bits that are 0 change nothing.
- R4: The interrupt output is the OR of all flag bits whose mask bit is 0.
- R5: Channel n occupies 0x40+16n. Full compare is at +0, half compare at +4, the counter at +8 (readable and writable) and the control word at +C. All four read back.
- R6: Control bit 0 selects the peripheral tick, bit 1 the slow tick and bit 2 the external tick. A channel advances only on cycles where a selected tick input is high.
- R7: Control bits 5:3 hold a prescale code c from 0 to 5. The counter then steps once for every 4^c selected ticks (1, 4, 16, 64, 256 or 1024). Writing the control word restarts the prescale count.
- R8: Prescale code 6 or 7, or a control word with none of bits 2:0 set, keeps the counter still.
- R9: A step adds 1 to the counter. A step taken while the counter equals full compare loads 0 and sets the channel flag.
- R10: The PWM output goes to 1 on the step that brings the counter to the half-compare value, and to 0 on the wrap step.
- R11: A channel whose enable bit is 0 holds its counter.
- R12: A wrap in the same cycle as a flag-clear write for that channel leaves the flag set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Asynchronous reset, active low |
| regWe | input | 1 | Register write strobe |
| regAddr | input | ADDR_W | Byte address of the register |
| regWdata | input | 32 | Write data |
| regRdata | output | 32 | Read data for regAddr, combinational |
| tickPclk | input | 1 | Peripheral clock enable pulse |
| tickRtc | input | 1 | 32.768 kHz enable pulse |
| tickExt | input | 1 | External clock enable pulse |
| pwmOut | output | NCH | PWM output of each channel |
| irq | output | 1 | Combined interrupt |

## Verification
The counting path is driven with bursts of peripheral ticks of different lengths, so the half-compare rise, the full-compare wrap and the hold at intermediate values can each be seen apart. A divide-by-four channel gets tick counts just below and past a multiple of four, which separates a correct prescaler from a step on every tick. Slow-clock ticks are applied to a peripheral-clock channel and to a slow-clock channel, and ticks are applied to channels that are disabled, set to code 6 or given no source. These cases show the source selection and every stop condition. Zero-valued alias writes, and a wrap that lands in the same cycle as a flag-clear, show that only the written ones change state and that a hardware event is never lost.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

  // width of the prescale counter (largest divisor is 4^5 = 1024)
  localparam int PRE_W = 10;

  // shared-vector register offsets
  localparam int OFF_EN_STAT   = 'h00;
  localparam int OFF_EN_SET    = 'h04;
  localparam int OFF_EN_CLR    = 'h08;
  localparam int OFF_FLAG_STAT = 'h10;
  localparam int OFF_FLAG_SET  = 'h14;
  localparam int OFF_FLAG_CLR  = 'h18;
  localparam int OFF_MASK_STAT = 'h20;
  localparam int OFF_MASK_SET  = 'h24;
  localparam int OFF_MASK_CLR  = 'h28;
  localparam int OFF_CH_BASE   = 'h40;

  typedef enum logic [1:0] {
    FLD_FULL = 2'd0,
    FLD_HALF = 2'd1,
    FLD_CNT  = 2'd2,
    FLD_CTL  = 2'd3
  } chField_e;

  // strobe bundle from the register control into the channel datapath
  typedef struct packed {
    logic      valid;
    logic [7:0] chan;
    chField_e  field;
    logic [15:0] data;
  } chWrite_t;

  // last value of the prescale count before a step: 4^code - 1
  function automatic logic [PRE_W-1:0] pre_limit(input logic [2:0] code);
    logic [PRE_W:0] pow;
    pow = (PRE_W+1)'(1) << {code, 1'b0};
    return PRE_W'(pow - 1'b1);
  endfunction

endpackage

// File: rtl/tmr_chan.sv
module tmr_chan
  import tmr_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int CH_ID = 0
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             en,
  input  logic             tickPclk,
  input  logic             tickRtc,
  input  logic             tickExt,
  input  chWrite_t         wr,
  output logic [CNT_W-1:0] cnt,
  output logic [CNT_W-1:0] full,
  output logic [CNT_W-1:0] half,
  output logic [5:0]       ctl,
  output logic             pwm,
  output logic             wrap
);

  logic [PRE_W-1:0] preCnt;
  logic [PRE_W-1:0] preLimit;
  logic             wrHit;
  logic             cntWr;
  logic             ctlWr;
  logic             srcTick;
  logic             codeOk;
  logic             run;
  logic             step;
  logic [CNT_W-1:0] cntInc;

  assign wrHit    = wr.valid && (wr.chan == 8'(CH_ID));
  assign cntWr    = wrHit && (wr.field == FLD_CNT);
  assign ctlWr    = wrHit && (wr.field == FLD_CTL);
  assign srcTick  = (ctl[0] & tickPclk) | (ctl[1] & tickRtc) | (ctl[2] & tickExt);
  assign codeOk   = (ctl[5:3] <= 3'd5);
  assign run      = en && codeOk && srcTick;
  assign preLimit = pre_limit(ctl[5:3]);
  assign step     = run && (preCnt == preLimit);
  assign cntInc   = cnt + 1'b1;
  assign wrap     = step && (cnt == full) && !cntWr;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      full <= '0;
      half <= '0;
      ctl  <= '0;
    end else if (wrHit) begin
      case (wr.field)
        FLD_FULL: full <= CNT_W'(wr.data);
        FLD_HALF: half <= CNT_W'(wr.data);
        FLD_CTL:  ctl  <= wr.data[5:0];
        default:  ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      preCnt <= '0;
    end else if (ctlWr) begin
      preCnt <= '0;
    end else if (run) begin
      preCnt <= (preCnt == preLimit) ? '0 : preCnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt <= '0;
      pwm <= 1'b0;
    end else begin
      if (cntWr)      cnt <= CNT_W'(wr.data);
      else if (wrap)  cnt <= '0;
      else if (step)  cnt <= cntInc;

      if (wrap)                                 pwm <= 1'b0;
      else if (step && !cntWr && cntInc == half) pwm <= 1'b1;
    end
  end

  // R9: a wrap step lands on zero
  assert_wrap_to_zero_R9: assert property (@(posedge clk) disable iff (!rstN)
    wrap |=> (cnt == '0));

  // R10: output low right after a wrap
  assert_pwm_low_after_wrap_R10: assert property (@(posedge clk) disable iff (!rstN)
    wrap |=> !pwm);

  // R11: disabled channel keeps its count unless software writes it
  assert_hold_when_disabled_R11: assert property (@(posedge clk) disable iff (!rstN)
    (!en && !cntWr) |=> $stable(cnt));

  // R8: unusable prescale code or no source keeps the count still
  assert_hold_when_stopped_R8: assert property (@(posedge clk) disable iff (!rstN)
    ((ctl[5:3] > 3'd5 || ctl[2:0] == 3'b000) && !cntWr) |=> $stable(cnt));

endmodule

// File: rtl/tmr_datapath.sv
module tmr_datapath
  import tmr_pkg::*;
#(
  parameter int NCH   = 4,
  parameter int CNT_W = 16
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic [NCH-1:0]            chanEn,
  input  logic                      tickPclk,
  input  logic                      tickRtc,
  input  logic                      tickExt,
  input  chWrite_t                  chWr,
  output logic [NCH-1:0][CNT_W-1:0] chCnt,
  output logic [NCH-1:0][CNT_W-1:0] chFull,
  output logic [NCH-1:0][CNT_W-1:0] chHalf,
  output logic [NCH-1:0][5:0]       chCtl,
  output logic [NCH-1:0]            pwmOut,
  output logic [NCH-1:0]            wrapOut
);

  for (genvar n = 0; n < NCH; n++) begin : g_chan
    tmr_chan #(.CNT_W(CNT_W), .CH_ID(n)) u_chan (
      .clk      (clk),
      .rstN     (rstN),
      .en       (chanEn[n]),
      .tickPclk (tickPclk),
      .tickRtc  (tickRtc),
      .tickExt  (tickExt),
      .wr       (chWr),
      .cnt      (chCnt[n]),
      .full     (chFull[n]),
      .half     (chHalf[n]),
      .ctl      (chCtl[n]),
      .pwm      (pwmOut[n]),
      .wrap     (wrapOut[n])
    );
  end

endmodule

// File: rtl/tmr_regctl.sv
module tmr_regctl
  import tmr_pkg::*;
#(
  parameter int NCH    = 4,
  parameter int CNT_W  = 16,
  parameter int ADDR_W = 8
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      regWe,
  input  logic [ADDR_W-1:0]         regAddr,
  input  logic [31:0]               regWdata,
  output logic [31:0]               regRdata,
  input  logic [NCH-1:0]            wrapIn,
  input  logic [NCH-1:0][CNT_W-1:0] chCnt,
  input  logic [NCH-1:0][CNT_W-1:0] chFull,
  input  logic [NCH-1:0][CNT_W-1:0] chHalf,
  input  logic [NCH-1:0][5:0]       chCtl,
  output logic [NCH-1:0]            chanEn,
  output chWrite_t                  chWr,
  output logic                      irq
);

  localparam logic [ADDR_W-1:0] CH_BASE = ADDR_W'(OFF_CH_BASE);

  logic [NCH-1:0]    enQ;
  logic [NCH-1:0]    flagQ;
  logic [NCH-1:0]    maskQ;
  logic [NCH-1:0]    wBits;
  logic [ADDR_W-1:0] chIdx;
  logic              chHit;
  chField_e          chFld;

  assign wBits = regWdata[NCH-1:0];
  assign chIdx = (regAddr - CH_BASE) >> 4;
  assign chHit = (regAddr >= CH_BASE) && (chIdx < ADDR_W'(NCH));
  assign chFld = chField_e'(regAddr[3:2]);

  function automatic logic hitAt(input logic [ADDR_W-1:0] a, input int off);
    return a == ADDR_W'(off);
  endfunction

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      enQ   <= '0;
      flagQ <= '0;
      maskQ <= '1;
    end else begin
      if (regWe && hitAt(regAddr, OFF_EN_SET))   enQ   <= enQ | wBits;
      if (regWe && hitAt(regAddr, OFF_EN_CLR))   enQ   <= enQ & ~wBits;
      if (regWe && hitAt(regAddr, OFF_MASK_SET)) maskQ <= maskQ | wBits;
      if (regWe && hitAt(regAddr, OFF_MASK_CLR)) maskQ <= maskQ & ~wBits;
      if (regWe && hitAt(regAddr, OFF_FLAG_SET))
        flagQ <= flagQ | wBits | wrapIn;
      else if (regWe && hitAt(regAddr, OFF_FLAG_CLR))
        flagQ <= (flagQ & ~wBits) | wrapIn;
      else
        flagQ <= flagQ | wrapIn;
    end
  end

  always_comb begin
    chWr.valid = regWe && chHit;
    chWr.chan  = 8'(chIdx);
    chWr.field = chFld;
    chWr.data  = regWdata[15:0];
  end

  always_comb begin
    regRdata = '0;
    if (hitAt(regAddr, OFF_EN_STAT))        regRdata[NCH-1:0] = enQ;
    else if (hitAt(regAddr, OFF_FLAG_STAT)) regRdata[NCH-1:0] = flagQ;
    else if (hitAt(regAddr, OFF_MASK_STAT)) regRdata[NCH-1:0] = maskQ;
    else begin
      for (int n = 0; n < NCH; n++) begin
        if (chHit && chIdx == ADDR_W'(n)) begin
          case (chFld)
            FLD_FULL: regRdata[CNT_W-1:0] = chFull[n];
            FLD_HALF: regRdata[CNT_W-1:0] = chHalf[n];
            FLD_CNT:  regRdata[CNT_W-1:0] = chCnt[n];
            default:  regRdata[5:0]       = chCtl[n];
          endcase
        end
      end
    end
  end

  assign chanEn = enQ;
  assign irq    = |(flagQ & ~maskQ);

  // R12: a hardware wrap always leaves its flag set
  assert_wrap_sets_flag_R12: assert property (@(posedge clk) disable iff (!rstN)
    (|wrapIn) |=> ((flagQ & $past(wrapIn)) == $past(wrapIn)));

  // R2: ones written to the clear alias end up cleared
  assert_en_clear_R2: assert property (@(posedge clk) disable iff (!rstN)
    (regWe && hitAt(regAddr, OFF_EN_CLR)) |=> ((enQ & $past(wBits)) == '0));

  // R3: zero data at the mask set alias leaves the mask untouched
  assert_mask_zero_write_R3: assert property (@(posedge clk) disable iff (!rstN)
    (regWe && hitAt(regAddr, OFF_MASK_SET) && wBits == '0) |=> $stable(maskQ));

endmodule

// File: rtl/pwm_timer_bank.sv
module pwm_timer_bank
  import tmr_pkg::*;
#(
  parameter int NCH    = 4,
  parameter int CNT_W  = 16,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWe,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [31:0]       regWdata,
  output logic [31:0]       regRdata,
  input  logic              tickPclk,
  input  logic              tickRtc,
  input  logic              tickExt,
  output logic [NCH-1:0]    pwmOut,
  output logic              irq
);

  logic [NCH-1:0]            chanEn;
  logic [NCH-1:0]            wrapVec;
  logic [NCH-1:0][CNT_W-1:0] chCnt;
  logic [NCH-1:0][CNT_W-1:0] chFull;
  logic [NCH-1:0][CNT_W-1:0] chHalf;
  logic [NCH-1:0][5:0]       chCtl;
  chWrite_t                  chWr;

  tmr_regctl #(.NCH(NCH), .CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_ctl (
    .clk      (clk),
    .rstN     (rstN),
    .regWe    (regWe),
    .regAddr  (regAddr),
    .regWdata (regWdata),
    .regRdata (regRdata),
    .wrapIn   (wrapVec),
    .chCnt    (chCnt),
    .chFull   (chFull),
    .chHalf   (chHalf),
    .chCtl    (chCtl),
    .chanEn   (chanEn),
    .chWr     (chWr),
    .irq      (irq)
  );

  tmr_datapath #(.NCH(NCH), .CNT_W(CNT_W)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .chanEn   (chanEn),
    .tickPclk (tickPclk),
    .tickRtc  (tickRtc),
    .tickExt  (tickExt),
    .chWr     (chWr),
    .chCnt    (chCnt),
    .chFull   (chFull),
    .chHalf   (chHalf),
    .chCtl    (chCtl),
    .pwmOut   (pwmOut),
    .wrapOut  (wrapVec)
  );

endmodule

// File: tb/pwm_timer_bank_bench.sv
module pwm_timer_bank_bench;

  localparam int NCH = 4;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWe = 1'b0;
  logic [7:0]  regAddr = '0;
  logic [31:0] regWdata = '0;
  logic [31:0] regRdata;
  logic        tickPclk = 1'b0;
  logic        tickRtc = 1'b0;
  logic        tickExt = 1'b0;
  logic [NCH-1:0] pwmOut;
  logic        irq;

  int total = 0;
  int bad = 0;
  bit done = 0;

  typedef struct {
    int          kind;   // 0 register read, 1 pwm vector, 2 irq
    logic [31:0] exp;
    string       tag;
  } item_t;
  item_t q[$];

  always #5 clk = ~clk;

  pwm_timer_bank u_pwm_timer_bank (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regAddr(regAddr),
    .regWdata(regWdata), .regRdata(regRdata), .tickPclk(tickPclk),
    .tickRtc(tickRtc), .tickExt(tickExt), .pwmOut(pwmOut), .irq(irq)
  );

  function automatic logic [7:0] chA(int n, int fld);
    return 8'(8'h40 + n * 16 + fld * 4);
  endfunction

  // monitor: compares the oldest expectation against the live outputs
  always @(negedge clk) begin
    if (q.size() > 0) begin
      item_t it;
      logic [31:0] act;
      it = q.pop_front();
      case (it.kind)
        0: act = regRdata;
        1: act = {28'd0, pwmOut};
        default: act = {31'd0, irq};
      endcase
      total++;
      if (act !== it.exp) begin
        bad++;
        $display("FAIL %s actual=%h expected=%h", it.tag, act, it.exp);
      end
    end
  end

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(posedge clk); #1;
    regWe = 1'b1; regAddr = a; regWdata = d;
    @(posedge clk); #1;
    regWe = 1'b0;
  endtask

  task automatic push(input int kind, input logic [7:0] a, input logic [31:0] e, input string tag);
    item_t it;
    @(posedge clk); #1;
    regAddr = a;
    it.kind = kind; it.exp = e; it.tag = tag;
    q.push_back(it);
    @(negedge clk); #1;
  endtask

  task automatic ticks(input int src, input int n);
    if (n > 0) begin
      @(posedge clk); #1;
      if (src == 0) tickPclk = 1'b1; else if (src == 1) tickRtc = 1'b1; else tickExt = 1'b1;
      repeat (n) @(posedge clk);
      #1;
      tickPclk = 1'b0; tickRtc = 1'b0; tickExt = 1'b0;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;

    // R1 reset state
    push(0, 8'h00, 32'h0, "R1 enable after reset");
    push(0, 8'h10, 32'h0, "R1 flag after reset");
    push(0, 8'h20, 32'hF, "R1 mask after reset");
    push(0, chA(0, 2), 32'h0, "R1 counter after reset");
    push(1, 8'h00, 32'h0, "R1 pwm after reset");
    push(2, 8'h00, 32'h0, "R1 irq after reset");

    // R5 channel 0 setup and readback
    wr(chA(0, 0), 32'd5);
    wr(chA(0, 1), 32'd2);
    wr(chA(0, 3), 32'h01);
    push(0, chA(0, 0), 32'd5, "R5 full readback");
    push(0, chA(0, 1), 32'd2, "R5 half readback");
    push(0, chA(0, 3), 32'h01, "R5 control readback");
    wr(8'h04, 32'h1);
    push(0, 8'h00, 32'h1, "R2 enable set");
    wr(8'h00, 32'hF);
    push(0, 8'h00, 32'h1, "R2 status address ignores writes");

    // R9/R10 counting, half rise, wrap
    ticks(0, 1);
    push(0, chA(0, 2), 32'd1, "R9 one step");
    push(1, 8'h00, 32'h0, "R10 pwm low below half");
    ticks(0, 1);
    push(1, 8'h00, 32'h1, "R10 pwm high at half");
    ticks(0, 3);
    push(0, chA(0, 2), 32'd5, "R9 counter at full");
    ticks(0, 1);
    push(0, chA(0, 2), 32'd0, "R9 wrap to zero");
    push(0, 8'h10, 32'h1, "R9 wrap sets flag");
    push(1, 8'h00, 32'h0, "R10 pwm low after wrap");
    push(2, 8'h00, 32'h0, "R4 masked flag no irq");

    // R3/R4 mask and flag aliases
    wr(8'h28, 32'h1);
    push(0, 8'h20, 32'hE, "R3 mask clear");
    push(2, 8'h00, 32'h1, "R4 unmasked flag raises irq");
    wr(8'h18, 32'h1);
    push(0, 8'h10, 32'h0, "R3 flag clear");
    push(2, 8'h00, 32'h0, "R4 irq drops");

    // R2/R3 zero bits change nothing
    wr(8'h08, 32'h0);
    push(0, 8'h00, 32'h1, "R2 zero clear write");
    wr(8'h24, 32'h0);
    push(0, 8'h20, 32'hE, "R3 zero mask set write");

    // R11 disabled channel holds
    wr(8'h08, 32'h1);
    push(0, 8'h00, 32'h0, "R2 enable clear");
    ticks(0, 5);
    push(0, chA(0, 2), 32'd0, "R11 disabled holds");

    // R7 divide by four
    wr(chA(1, 0), 32'd100);
    wr(chA(1, 3), 32'h09);
    wr(8'h04, 32'h2);
    ticks(0, 3);
    push(0, chA(1, 2), 32'd0, "R7 no step before fourth tick");
    ticks(0, 1);
    push(0, chA(1, 2), 32'd1, "R7 step on fourth tick");
    ticks(0, 8);
    push(0, chA(1, 2), 32'd3, "R7 three steps after twelve ticks");

    // R6 source selection
    wr(chA(2, 0), 32'd100);
    wr(chA(2, 3), 32'h02);
    wr(8'h04, 32'h4);
    ticks(0, 4);
    push(0, chA(2, 2), 32'd0, "R6 slow channel ignores peripheral tick");
    push(0, chA(1, 2), 32'd4, "R6 peripheral channel counts its tick");
    ticks(1, 3);
    push(0, chA(2, 2), 32'd3, "R6 slow channel counts slow tick");
    push(0, chA(1, 2), 32'd4, "R6 peripheral channel ignores slow tick");

    // R8 stopped codes
    wr(chA(3, 0), 32'd100);
    wr(chA(3, 3), 32'h31);
    wr(8'h04, 32'h8);
    ticks(0, 4);
    push(0, chA(3, 2), 32'd0, "R8 code six stopped");
    wr(chA(3, 3), 32'h00);
    ticks(0, 4);
    push(0, chA(3, 2), 32'd0, "R8 no source stopped");

    // R3 flag set alias, R4 irq from channel 3
    wr(8'h14, 32'h8);
    push(0, 8'h10, 32'h8, "R3 flag set alias");
    wr(8'h28, 32'h8);
    push(2, 8'h00, 32'h1, "R4 irq from set flag");

    // R12 wrap collides with flag clear
    wr(chA(0, 2), 32'd5);
    push(0, chA(0, 2), 32'd5, "R5 counter write");
    wr(8'h04, 32'h1);
    @(posedge clk); #1;
    regWe = 1'b1; regAddr = 8'h18; regWdata = 32'h1; tickPclk = 1'b1;
    @(posedge clk); #1;
    regWe = 1'b0; tickPclk = 1'b0;
    push(0, 8'h10, 32'h9, "R12 wrap wins over clear");
    push(0, chA(0, 2), 32'd0, "R12 counter wrapped");

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule